// File: doc/BRIEF.md
# Receive Word Buffer with Overwrite-on-Full

This block holds validated 32-bit words from an upstream receiver until a host collects them. Each word comes in on a one-cycle end-of-sequence strobe together with its 32-bit value. The block keeps up to 32 words in arrival order. It drives three active-low status outputs: data-ready, full and half-full. The half-full output can serve as an interrupt that starts a 16-word burst read.

The host reads over a 16-bit path. It asserts the read enable and uses the half-select input to choose which half of the oldest word appears. A word leaves the buffer only when its upper half is read, so the host can read the lower half any number of times without losing the word. When the buffer is full and a new word arrives, the new word replaces the newest stored word (slot 32) and is not dropped.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset, `ready_n`, `full_n` and `half_n` are 1 and `rd_data` is 0.
- R2: A `wr_stb` pulse stores `wr_word`. From the next clock cycle `ready_n` is 0.
- R3: While `rd_en` is 1 and the buffer is not empty, `rd_data` shows bits [15:0] of the oldest word when `rd_sel` is 0 and bits [31:16] when `rd_sel` is 1, in the same cycle. In every other case `rd_data` is 0.
- R4: A read with `rd_sel` 0 never removes a word. A word is removed at the clock edge where `rd_en` and `rd_sel` are both 1.
- R5: Words come out in the order they were stored.
- R6: `full_n` is 0 exactly when 32 words are held.
- R7: `half_n` is 0 exactly when 16 or more words are held.
- R8: A strobe while full, with no removal in that cycle, replaces the newest word. The count stays at 32 and all older words are kept.
- R9: A strobe and a removal in the same cycle leave the count unchanged and append the new word, including when the buffer is full.
- R10: `ready_n` returns to 1 only after a removal leaves the buffer empty.
- R11: A removal request while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | End-of-sequence strobe for a valid word |
| wr_word | input | 32 | Received word |
| rd_en | input | 1 | Host read enable |
| rd_sel | input | 1 | Half select: 0 selects bits [15:0], 1 selects bits [31:16] and removes the word |
| rd_data | output | 16 | Selected half of the oldest word |
| ready_n | output | 1 | Active-low data ready |
| full_n | output | 1 | Active-low full |
| half_n | output | 1 | Active-low half full (16 or more words) |

## Verification
The three flags follow an occupancy register, so a strobe or a removal shows up on them in the cycle after the clock edge that samples it. `rd_data` is combinational and follows `rd_en` and `rd_sel` in the same cycle. The bench changes inputs on the falling edge and compares all outputs against a queue model 1 ns later. It updates the model at the rising edge, so each expected value belongs to the cycle in which it is due. The runs include reads of the lower half only, removals while empty, repeated overwrites at full, a strobe and a removal together at full, and a complete drain.

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [WIDTH-1:0]   wr_word,
  input  logic               rd_en,
  input  logic               rd_sel,
  output logic [WIDTH/2-1:0] rd_data,
  output logic               ready_n,
  output logic               full_n,
  output logic               half_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = WIDTH / 2;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;

  logic empty, full, pop, push, ovw;
  logic [WIDTH-1:0] head;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign pop   = rd_en && rd_sel && !empty;
  assign push  = wr_stb && (!full || pop);
  assign ovw   = wr_stb && full && !pop;
  assign head  = mem[rd_ptr];

  assign rd_data = (rd_en && !empty) ? (rd_sel ? head[WIDTH-1:HW] : head[HW-1:0]) : '0;
  assign ready_n = empty;
  assign full_n  = !full;
  assign half_n  = !(count >= CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_word;
    else if (ovw) mem[wr_ptr - AW'(1)] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      if (push) wr_ptr <= wr_ptr + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R2
  r2_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !ready_n);
  // R8
  r8_stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_stb && !(rd_en && rd_sel)) |=> !full_n);
  // R10
  r10_ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(rd_en && rd_sel));
  // R7
  r7_full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);
  // R11
  r11_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n == 1'b0 && !wr_stb) |=> ready_n);
  // R4
  r4_low_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && !wr_stb && !(rd_en && rd_sel)) |=> $stable(half_n) && $stable(full_n) && !ready_n);
endmodule

// File: tb/sim_rx_word_fifo.sv
module sim_rx_word_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [31:0] wr_word = '0;
  logic rd_en = 1'b0;
  logic rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic ready_n, full_n, half_n;

  int checks = 0;
  int errors = 0;
  logic [31:0] q[$];

  always #10 clk = ~clk;

  rx_word_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .ready_n(ready_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [15:0] ed;
    ed = (rd_en && q.size() > 0) ? (rd_sel ? q[0][31:16] : q[0][15:0]) : 16'h0;
    chk({tag, "/R3"}, "rd_data", 32'(rd_data), 32'(ed));
    chk({tag, "/R10"}, "ready_n", 32'(ready_n), 32'(q.size() == 0));
    chk({tag, "/R6"}, "full_n", 32'(full_n), 32'(q.size() != 32));
    chk({tag, "/R7"}, "half_n", 32'(half_n), 32'(q.size() < 16));
  endtask

  task automatic step(input string tag, input logic s, input logic [31:0] w, input logic e, input logic sl);
    bit pop;
    @(negedge clk);
    wr_stb = s; wr_word = w; rd_en = e; rd_sel = sl;
    #1 compare(tag);
    @(posedge clk);
    pop = e && sl && q.size() > 0;
    if (pop) void'(q.pop_front());
    if (s) begin
      if (q.size() == 32) q[31] = w;
      else q.push_back(w);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 compare("R1");
    step("R11", 0, 0, 1, 1);
    step("R11", 0, 0, 1, 0);
    step("R2", 1, 32'hA1B2C3D4, 0, 0);
    step("R2", 1, 32'h11112222, 0, 0);
    step("R2", 1, 32'h33334444, 0, 0);
    for (int i = 0; i < 3; i++) step("R4", 0, 0, 1, 0);
    step("R3", 0, 0, 1, 1);
    step("R5", 0, 0, 1, 0);
    step("R5", 0, 0, 1, 1);
    step("R9", 1, 32'h5555AAAA, 1, 1);
    step("R5", 0, 0, 1, 1);
    step("R10", 0, 0, 1, 1);
    step("R10", 0, 0, 1, 1);
    step("R11", 0, 0, 0, 1);
    for (int i = 0; i < 32; i++) step("R7", 1, {16'(i), 16'(~i)}, 0, 0);
    step("R6", 0, 0, 1, 0);
    step("R8", 1, 32'hDEADBEEF, 0, 0);
    step("R8", 1, 32'hCAFEF00D, 1, 0);
    step("R9", 1, 32'h0BADC0DE, 1, 1);
    step("R6", 0, 0, 0, 0);
    for (int i = 0; i < 34; i++) step("R5", 0, 0, 1, (i % 3) != 0);
    for (int i = 0; i < 20; i++) step("R10", 0, 0, 1, 1);
    for (int i = 0; i < 40; i++) step("R9", (i % 2) == 0, 32'h7000_0000 + 32'(i), 1, (i % 4) == 1);
    for (int i = 0; i < 40; i++) step("R10", 0, 0, 1, 1);
    @(negedge clk); rd_en = 0; rd_sel = 0;
    #1 compare("R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule